// File: doc/BRIEF.md
# LIN Break and Mute Control

This block sits beside the character shifter of a UART-style serial port that can run plain, as a LIN master, or as a LIN slave. It decides when a break must be placed on the transmit line, how long it lasts, and when the line must be held recessive afterwards. It watches the receive line for a long dominant run that marks the start of a frame header, and it keeps the receiver mute bit, arbitrating between software writes and the hardware wake-up event.

All line-timing work advances on a one-cycle `bit_tick` strobe that the baud generator issues once per bit time. The mute bit and the request latching are evaluated on every clock. The shifter uses `brk_tx_low` to force the line low, and waits while `brk_tx_busy` is high. Software sees `brk_flag` and `mute_q`.

Top module: `lin_brk_mute_ctl`

## Requirements
- R1: `mode_sel` decodes as follows: bit 1 clear selects the plain (non-LIN) mode, `2'b10` selects master, `2'b11` selects slave.
- R2: In master mode a break holds `brk_tx_low` high for exactly 13 bit ticks.
- R3: In plain mode a break holds `brk_tx_low` high for exactly 10 bit ticks.
- R4: A pending break starts only at a bit tick where `tx_busy` is low. While `tx_busy` is high, `brk_tx_low` stays low.
- R5: A rising edge of `sbk_req` latches a request. If `sbk_req` is set and then cleared, exactly one break is still sent, once the current word has finished.
- R6: If `sbk_req` is still high when a break's guard bit ends, one further break follows.
- R7: Each break's low phase is followed by exactly one bit tick in which `brk_tx_busy` is high and `brk_tx_low` is low.
- R8: In slave mode `sbk_req` has no effect: `brk_tx_low` and `brk_tx_busy` stay low.
- R9: In slave mode, the 11th consecutive bit tick that samples `rxd` low sets `brk_flag`. A run of 10 does not set it. A run that continues past 11 does not set it again after a clear.
- R10: `brk_flag` stays set until a `brk_clr` pulse clears it. A new detection in the same cycle wins over the clear.
- R11: Outside slave mode no dominant run sets `brk_flag`.
- R12: `mute_q` (1 = muted) resets to 0 and takes `mute_wr_val` on `mute_wr_en`. `wake_det` clears it, and `wake_det` takes priority over a write in the same cycle.
- R13: In slave mode, software writes to `mute_q` are ignored while `rdrf` is high. In master mode they are accepted regardless of `rdrf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe, once per bit time |
| mode_sel | input | 2 | Mode selection (see R1) |
| sbk_req | input | 1 | Send-break control bit |
| tx_busy | input | 1 | Shifter is sending a word |
| rxd | input | 1 | Serial receive line, low = dominant |
| brk_clr | input | 1 | One-cycle clear of the break-detected flag |
| mute_wr_en | input | 1 | Software write strobe for the mute bit |
| mute_wr_val | input | 1 | Value for the software mute write |
| wake_det | input | 1 | Hardware wake-up sequence recognised |
| rdrf | input | 1 | Received data ready flag |
| brk_tx_low | output | 1 | Force transmit line low (break bits) |
| brk_tx_busy | output | 1 | Break or its guard bit in progress |
| brk_flag | output | 1 | Sticky break-detected flag |
| mute_q | output | 1 | Receiver mute state |

## Verification
Break generation is tried in four ways: a single request pulse in master mode and in plain mode, where the measured low length tells the 13-bit setting from the 10-bit one; a pulse made while the shifter is busy, which separates a level-sampled request from a latched one; a request held across a whole break, which shows the re-arm; and requests in slave mode, which must produce nothing. For detection, a dominant run of 10 ticks is compared with one of 11, which exposes any off-by-one in the count. A run that continues through a clear checks that only one capture is made, and a run in master mode checks that detection is gated by mode. For the mute bit, writes are applied with and without `rdrf` in both LIN modes, and against a simultaneous wake-up, which shows the lock and the priority.

// File: rtl/lbm_pkg.sv
package lbm_pkg;

  typedef enum logic [1:0] {
    LM_OFF = 2'b00,
    LM_MST = 2'b10,
    LM_SLV = 2'b11
  } lin_mode_e;

  typedef enum logic [1:0] {
    BT_IDLE  = 2'b00,
    BT_LOW   = 2'b01,
    BT_GUARD = 2'b10
  } brk_st_e;

  // R1: mode field decode, bit 1 clear means plain operation
  function automatic lin_mode_e decode_mode(input logic [1:0] sel);
    case (sel)
      2'b10:   return LM_MST;
      2'b11:   return LM_SLV;
      default: return LM_OFF;
    endcase
  endfunction

  // break length in bit times for a transmitting mode
  function automatic int unsigned brk_bits(input lin_mode_e m,
                                           input int unsigned off_bits,
                                           input int unsigned mst_bits);
    return (m == LM_MST) ? mst_bits : off_bits;
  endfunction

  // saturating run-length step
  function automatic int unsigned run_step(input int unsigned run,
                                           input int unsigned cap);
    return (run >= cap) ? cap : run + 1;
  endfunction

endpackage

// File: rtl/lbm_brk_tx.sv
module lbm_brk_tx
  import lbm_pkg::*;
#(
  parameter int unsigned OFF_BITS = 10,
  parameter int unsigned MST_BITS = 13
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_tick,
  input  lin_mode_e mode,
  input  logic      sbk_req,
  input  logic      tx_busy,
  output logic      brk_low,
  output logic      brk_busy
);

  localparam int unsigned MAX_BITS = (OFF_BITS > MST_BITS) ? OFF_BITS : MST_BITS;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

  brk_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             sbk_d;
  logic             pending_q;

  // named internal events
  logic is_slave, sbk_rise, start_ev, low_done, guard_done, rearm_ev;

  assign is_slave   = (mode == LM_SLV);
  assign sbk_rise   = sbk_req & ~sbk_d;
  assign start_ev   = bit_tick & (state_q == BT_IDLE) & pending_q & ~tx_busy & ~is_slave;
  assign low_done   = bit_tick & (state_q == BT_LOW) & (cnt_q == len_q - CNT_W'(1));
  assign guard_done = bit_tick & (state_q == BT_GUARD);
  assign rearm_ev   = guard_done & sbk_req & ~is_slave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbk_d <= 1'b0;
    end else begin
      sbk_d <= sbk_req;
    end
  end

  // request latch: survives a set-then-clear of the control bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (is_slave) begin
      pending_q <= 1'b0;
    end else if (sbk_rise || rearm_ev) begin
      pending_q <= 1'b1;
    end else if (start_ev) begin
      pending_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BT_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (is_slave) begin
      state_q <= BT_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        BT_IDLE: begin
          if (start_ev) begin
            state_q <= BT_LOW;
            cnt_q   <= '0;
            len_q   <= CNT_W'(brk_bits(mode, OFF_BITS, MST_BITS));
          end
        end
        BT_LOW: begin
          if (low_done) begin
            state_q <= BT_GUARD;
            cnt_q   <= '0;
          end else if (bit_tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        BT_GUARD: begin
          if (guard_done) begin
            state_q <= BT_IDLE;
          end
        end
        default: state_q <= BT_IDLE;
      endcase
    end
  end

  assign brk_low  = (state_q == BT_LOW);
  assign brk_busy = (state_q != BT_IDLE);

  assert_slave_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_slave |=> (state_q == BT_IDLE));

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BT_LOW) |-> (cnt_q < len_q));

  assert_guard_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (low_done && !is_slave) |=> (state_q == BT_GUARD));

  assert_start_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_low) |-> $past(bit_tick && !tx_busy));

endmodule

// File: rtl/lbm_brk_det.sv
module lbm_brk_det
  import lbm_pkg::*;
#(
  parameter int unsigned DET_BITS = 11
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bit_tick,
  input  lin_mode_e mode,
  input  logic      rxd,
  input  logic      brk_clr,
  output logic      brk_flag,
  output logic      brk_hit
);

  localparam int unsigned RUN_W = $clog2(DET_BITS + 1);

  logic [RUN_W-1:0] run_q;
  logic             flag_q;
  logic             is_slave;

  assign is_slave = (mode == LM_SLV);
  // the sample that completes the run fires exactly once
  assign brk_hit  = bit_tick & is_slave & ~rxd & (run_q == RUN_W'(DET_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!is_slave) begin
      run_q <= '0;
    end else if (bit_tick) begin
      if (rxd) run_q <= '0;
      else     run_q <= RUN_W'(run_step(int'(run_q), DET_BITS));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (brk_hit) begin
      flag_q <= 1'b1;
    end else if (brk_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign brk_flag = flag_q;

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !brk_clr) |=> flag_q);

  assert_flag_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(bit_tick && !rxd && is_slave));

  assert_no_run_off_slave_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !is_slave |=> (run_q == '0));

endmodule

// File: rtl/lbm_mute_arb.sv
module lbm_mute_arb
  import lbm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lin_mode_e mode,
  input  logic      wr_en,
  input  logic      wr_val,
  input  logic      wake,
  input  logic      rdrf,
  output logic      mute
);

  logic locked, wr_ok, mute_q;

  assign locked = (mode == LM_SLV) & rdrf;
  assign wr_ok  = wr_en & ~locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= 1'b0;
    end else if (wake) begin
      mute_q <= 1'b0;
    end else if (wr_ok) begin
      mute_q <= wr_val;
    end
  end

  assign mute = mute_q;

  assert_wake_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !mute_q);

  assert_locked_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !wake) |=> $stable(mute_q));

endmodule

// File: rtl/lin_brk_mute_ctl.sv
module lin_brk_mute_ctl
  import lbm_pkg::*;
#(
  parameter int unsigned OFF_BRK_BITS = 10,
  parameter int unsigned MST_BRK_BITS = 13,
  parameter int unsigned SLV_DET_BITS = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic [1:0] mode_sel,
  input  logic       sbk_req,
  input  logic       tx_busy,
  input  logic       rxd,
  input  logic       brk_clr,
  input  logic       mute_wr_en,
  input  logic       mute_wr_val,
  input  logic       wake_det,
  input  logic       rdrf,
  output logic       brk_tx_low,
  output logic       brk_tx_busy,
  output logic       brk_flag,
  output logic       mute_q
);

  lin_mode_e mode;
  logic      det_hit;

  assign mode = decode_mode(mode_sel);

  lbm_brk_tx #(
    .OFF_BITS (OFF_BRK_BITS),
    .MST_BITS (MST_BRK_BITS)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .mode     (mode),
    .sbk_req  (sbk_req),
    .tx_busy  (tx_busy),
    .brk_low  (brk_tx_low),
    .brk_busy (brk_tx_busy)
  );

  lbm_brk_det #(
    .DET_BITS (SLV_DET_BITS)
  ) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .mode     (mode),
    .rxd      (rxd),
    .brk_clr  (brk_clr),
    .brk_flag (brk_flag),
    .brk_hit  (det_hit)
  );

  lbm_mute_arb u_mute (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .wr_en  (mute_wr_en),
    .wr_val (mute_wr_val),
    .wake   (wake_det),
    .rdrf   (rdrf),
    .mute   (mute_q)
  );

  // R1/R8: the transmit side never drives a break while the slave decode is active
  assert_slave_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> !brk_tx_low || (mode_sel != 2'b11));

  assert_hit_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    det_hit |=> brk_flag);

endmodule

// File: tb/lin_brk_mute_ctl_tb.sv
module lin_brk_mute_ctl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       sbk_req = 1'b0;
  logic       tx_busy = 1'b0;
  logic       rxd = 1'b1;
  logic       brk_clr = 1'b0;
  logic       mute_wr_en = 1'b0;
  logic       mute_wr_val = 1'b0;
  logic       wake_det = 1'b0;
  logic       rdrf = 1'b0;
  logic       brk_tx_low, brk_tx_busy, brk_flag, mute_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int    exp_len_q[$];
  string exp_tag_q[$];

  always #10 clk = ~clk;

  lin_brk_mute_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode_sel(mode_sel),
    .sbk_req(sbk_req), .tx_busy(tx_busy), .rxd(rxd), .brk_clr(brk_clr),
    .mute_wr_en(mute_wr_en), .mute_wr_val(mute_wr_val), .wake_det(wake_det),
    .rdrf(rdrf), .brk_tx_low(brk_tx_low), .brk_tx_busy(brk_tx_busy),
    .brk_flag(brk_flag), .mute_q(mute_q)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one bit time: strobe for one clock, then three quiet clocks
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expect_brk(input int len, input string tag);
    exp_len_q.push_back(len);
    exp_tag_q.push_back(tag);
  endtask

  task automatic pulse_sbk();
    @(negedge clk) sbk_req = 1'b1;
    @(negedge clk) sbk_req = 1'b0;
  endtask

  task automatic mute_op(input logic en, input logic val, input logic wk);
    @(negedge clk);
    mute_wr_en = en; mute_wr_val = val; wake_det = wk;
    @(negedge clk);
    mute_wr_en = 1'b0; wake_det = 1'b0;
  endtask

  // monitor: measures each low run and the recessive guard that follows
  initial begin
    int  run_len = 0;
    int  glen = 0;
    bit  guard_open = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      if (bit_tick) begin
        if (brk_tx_low) begin
          if (guard_open) begin
            chk("R7 guard ticks", glen, 1);
            guard_open = 1'b0; glen = 0;
          end
          run_len++;
        end else begin
          if (run_len > 0) begin
            if (exp_len_q.size() == 0) begin
              chk("R8 unexpected break length", run_len, 0);
            end else begin
              chk(exp_tag_q.pop_front(), run_len, exp_len_q.pop_front());
            end
            run_len = 0; guard_open = 1'b1; glen = 0;
          end
          if (guard_open) begin
            if (brk_tx_busy) glen++;
            else begin
              chk("R7 guard ticks", glen, 1);
              guard_open = 1'b0; glen = 0;
            end
          end
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset mute", mute_q, 0);
    chk("R10 reset flag", brk_flag, 0);
    chk("R2 reset low", brk_tx_low, 0);
    chk("R7 reset busy", brk_tx_busy, 0);

    // R2: master break length
    mode_sel = 2'b10;
    expect_brk(13, "R2 master break length");
    pulse_sbk();
    tick(20);

    // R3: plain mode break length
    mode_sel = 2'b00;
    expect_brk(10, "R3 plain break length");
    pulse_sbk();
    tick(16);

    // R4/R5: pulse while a word is in flight
    mode_sel = 2'b10;
    tx_busy = 1'b1;
    expect_brk(13, "R5 set-then-clear break");
    pulse_sbk();
    tick(5);
    chk("R4 no break while busy", brk_tx_low, 0);
    tx_busy = 1'b0;
    tick(20);
    chk("R5 exactly one break", exp_len_q.size(), 0);

    // R6: held request re-arms once
    expect_brk(13, "R6 first held break");
    expect_brk(13, "R6 second held break");
    @(negedge clk) sbk_req = 1'b1;
    tick(20);
    sbk_req = 1'b0;
    tick(20);
    chk("R6 two breaks seen", exp_len_q.size(), 0);

    // R8: slave mode ignores the request
    mode_sel = 2'b11;
    pulse_sbk();
    @(negedge clk) sbk_req = 1'b1;
    tick(18);
    chk("R8 slave busy stays low", brk_tx_busy, 0);
    sbk_req = 1'b0;
    tick(2);

    // R9: 10 vs 11 dominant ticks
    rxd = 1'b0; tick(10); rxd = 1'b1;
    chk("R9 ten low ticks", brk_flag, 0);
    tick(1);
    rxd = 1'b0; tick(11);
    chk("R9 eleven low ticks", brk_flag, 1);
    rxd = 1'b1; tick(3);
    chk("R10 flag sticky", brk_flag, 1);
    @(negedge clk) brk_clr = 1'b1;
    @(negedge clk) brk_clr = 1'b0;
    chk("R10 flag cleared", brk_flag, 0);

    // R9: long run captures once only
    rxd = 1'b0; tick(12);
    chk("R9 long run sets", brk_flag, 1);
    @(negedge clk) brk_clr = 1'b1;
    @(negedge clk) brk_clr = 1'b0;
    tick(6);
    chk("R9 no re-capture in same run", brk_flag, 0);
    rxd = 1'b1; tick(1);

    // R11: master mode never detects
    mode_sel = 2'b10;
    rxd = 1'b0; tick(14); rxd = 1'b1;
    chk("R11 master no detect", brk_flag, 0);
    tick(1);

    // R12: writes, wake-up, priority
    mode_sel = 2'b00;
    mute_op(1'b1, 1'b1, 1'b0);
    chk("R12 write mute", mute_q, 1);
    mute_op(1'b0, 1'b0, 1'b1);
    chk("R12 wake clears", mute_q, 0);
    mute_op(1'b1, 1'b1, 1'b1);
    chk("R12 wake beats write", mute_q, 0);

    // R13: slave lock while data pending
    mode_sel = 2'b11;
    rdrf = 1'b1;
    mute_op(1'b1, 1'b1, 1'b0);
    chk("R13 slave locked write", mute_q, 0);
    rdrf = 1'b0;
    mute_op(1'b1, 1'b1, 1'b0);
    chk("R13 slave unlocked write", mute_q, 1);
    rdrf = 1'b1;
    mute_op(1'b1, 1'b0, 1'b0);
    chk("R13 slave locked clear", mute_q, 1);
    mode_sel = 2'b10;
    mute_op(1'b1, 1'b0, 1'b0);
    chk("R13 master accepts with rdrf", mute_q, 0);
    rdrf = 1'b0;

    tick(2);
    chk("R2 no stray breaks", exp_len_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule